// File: doc/BRIEF.md
# Transmit Descriptor and Early Threshold Controller

This block holds four transmit descriptors, which are used strictly in rotation, and decides when the transmitter may start sending the current one. Each descriptor is a 32-bit word. Software writes the byte count, an early-start threshold code and the ownership flag. Hardware fills in the completion status and sets the ownership flag when the DMA for that descriptor has finished. Writing a descriptor always rewrites its byte count, and that write also wipes any status left from the previous use.

A start is allowed once the transmit FIFO holds at least the threshold number of bytes, or once it holds a whole packet. The start is given as a one-cycle pulse. The descriptor pointer moves on when the MAC reports that transmission has completed. After a long descriptor (more than 1792 bytes), the next descriptor is held back until the DMA has handed the long one back by setting its ownership flag.

Top module: `tx_desc_ctrl`

## Requirements
- R1: After reset every descriptor reads 0x0000_2000 (only the ownership flag, bit 13, is set), `cur_idx` is 0 and `tx_start` is low.
- R2: A write with all four byte enables set loads size (bits 12:0), ownership (bit 13) and threshold code (bits 21:16), and the descriptor reads back with these fields.
- R3: A write with any byte enable clear is ignored, and the descriptor keeps its old value.
- R4: A full write clears the status bits 31:24 and 15:14. Ones written to those bits have no effect.
- R5: `dma_done` sets the ownership flag (bit 13) of the descriptor selected by `dma_idx` on the next clock.
- R6: On completion the current descriptor records its status: carrier lost at bit 31, abort at 30, late collision at 29, heartbeat fail at 28, collision count at 27:24, TX OK at 15 and underrun at 14. The heartbeat bit is recorded as 0 while `speed100` is high.
- R7: Threshold code 0 means 8 bytes. With no whole packet in the FIFO, a start needs `fifo_bytes` >= 8.
- R8: Threshold code n (1 to 63) means n*32 bytes. A start happens at `fifo_bytes` = n*32 and not at n*32-1.
- R9: `fifo_pkt_ready` allows a start whatever the threshold and byte count.
- R10: A descriptor is eligible only when its ownership flag is 0 and its size is non-zero. `tx_start` is a one-cycle pulse that rises on the clock after the condition holds, and it does not rise again until `tx_done` has been seen.
- R11: `tx_done` while a transmission is in progress advances `cur_idx` by one, wrapping from 3 to 0.
- R12: After a descriptor with a size above 1792 completes, the next descriptor does not start until the long one's ownership flag is set. A size of exactly 1792 causes no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 2 | Descriptor being written |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 2 | Descriptor to read |
| rd_data | output | 32 | Registered read data |
| fifo_bytes | input | 12 | Bytes now in the transmit FIFO |
| fifo_pkt_ready | input | 1 | FIFO holds at least one whole packet |
| dma_done | input | 1 | DMA finished a descriptor |
| dma_idx | input | 2 | Descriptor the DMA finished |
| tx_done | input | 1 | MAC finished the current transmission |
| tx_ok | input | 1 | Completion status: sent correctly |
| tx_underrun | input | 1 | Completion status: FIFO underrun |
| tx_abort | input | 1 | Completion status: aborted |
| tx_carrier_lost | input | 1 | Completion status: carrier lost |
| tx_late_coll | input | 1 | Completion status: late collision |
| tx_hb_fail | input | 1 | Completion status: heartbeat missing |
| tx_coll_cnt | input | 4 | Completion status: collision count |
| speed100 | input | 1 | Link runs at 100 Mb/s |
| tx_start | output | 1 | One-cycle start pulse |
| cur_idx | output | 2 | Current descriptor index |

## Verification
A table drives the start decision with FIFO levels one below and exactly at the threshold, for code 0 (8 bytes), for small codes and for the largest code. These pairs separate a correct decode from an off-by-one error, from a missing 8-byte special case and from a `>` compare used in place of `>=`. Rows with a whole packet and a byte count below the threshold show that the packet flag bypasses the threshold. Each start in the table also steps the pointer, so the wrap from 3 to 0 is covered. Directed cases cover a 1793-byte descriptor against a 1792-byte one, status capture with and without the heartbeat forcing, and zero-size and hardware-owned descriptors.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;
  localparam int WORD_W = 32;
  localparam int THR_W  = 6;

  // Bit positions inside a descriptor word
  localparam int B_CRS  = 31;
  localparam int B_ABT  = 30;
  localparam int B_OWC  = 29;
  localparam int B_HB   = 28;
  localparam int B_NCC  = 24;
  localparam int B_THR  = 16;
  localparam int B_TOK  = 15;
  localparam int B_TUN  = 14;
  localparam int B_OWN  = 13;

  typedef struct packed {
    logic       crs;
    logic       abt;
    logic       owc;
    logic       hb;
    logic [3:0] ncc;
    logic       tok;
    logic       tun;
  } tx_stat_t;

  // Code 0 is a fixed 8-byte level, any other code counts 32-byte units
  function automatic logic [11:0] thr_to_bytes(input logic [THR_W-1:0] code);
    if (code == '0) return 12'd8;
    return {1'b0, code, 5'b0};
  endfunction
endpackage

// File: rtl/tx_desc_reg.sv
module tx_desc_reg
  import tx_desc_pkg::*;
#(
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_full,
  input  logic              wr_part,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              done_hit,
  input  tx_stat_t          stat_in,
  input  logic              speed100,
  input  logic              own_set,
  output logic [WORD_W-1:0] q
);
  logic [SIZE_W-1:0] size_r;
  logic [THR_W-1:0]  thr_r;
  logic              own_r;
  tx_stat_t          stat_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      size_r <= '0;
      thr_r  <= '0;
      own_r  <= 1'b1;
      stat_r <= '0;
    end else begin
      if (wr_full) begin
        size_r <= wr_data[SIZE_W-1:0];
        thr_r  <= wr_data[B_THR +: THR_W];
        own_r  <= wr_data[B_OWN];
        stat_r <= '0;
      end
      if (done_hit) begin
        stat_r    <= stat_in;
        stat_r.hb <= stat_in.hb & ~speed100;
      end
      if (own_set) own_r <= 1'b1;
    end
  end

  always_comb begin
    q = '0;
    q[SIZE_W-1:0]     = size_r;
    q[B_OWN]          = own_r;
    q[B_TUN]          = stat_r.tun;
    q[B_TOK]          = stat_r.tok;
    q[B_THR +: THR_W] = thr_r;
    q[B_NCC +: 4]     = stat_r.ncc;
    q[B_HB]           = stat_r.hb;
    q[B_OWC]          = stat_r.owc;
    q[B_ABT]          = stat_r.abt;
    q[B_CRS]          = stat_r.crs;
  end

  // R3
  part_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_part && !wr_full && !done_hit && !own_set) |=> $stable(q));

  // R4
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_full && !done_hit) |=> (q[31:24] == 8'h00 && q[15:14] == 2'b00));

  // R6
  hb_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (done_hit && speed100) |=> !q[B_HB]);

  // R5
  own_set_chk: assert property (@(posedge clk) disable iff (rst)
    own_set |=> q[B_OWN]);
endmodule

// File: rtl/tx_start_ctrl.sv
module tx_start_ctrl
  import tx_desc_pkg::*;
#(
  parameter int NUM_DESC   = 4,
  parameter int CNT_W      = 12,
  parameter int SIZE_W     = 13,
  parameter int LONG_LIMIT = 1792,
  localparam int PW        = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] desc_q [NUM_DESC],
  input  logic [CNT_W-1:0]  fifo_bytes,
  input  logic              fifo_pkt_ready,
  input  logic              tx_done,
  output logic              tx_start,
  output logic              busy,
  output logic [PW-1:0]     cur_idx
);
  localparam logic [PW-1:0] LAST = PW'(NUM_DESC - 1);

  typedef enum logic {S_IDLE, S_BUSY} st_t;
  st_t st;

  logic              prev_long;
  logic [PW-1:0]     prev_idx;
  logic [WORD_W-1:0] cur_w;
  logic [CNT_W-1:0]  thr_b;
  logic              eligible, hold, level_ok, go;

  always_comb begin
    cur_w    = desc_q[cur_idx];
    thr_b    = CNT_W'(thr_to_bytes(cur_w[B_THR +: THR_W]));
    eligible = !cur_w[B_OWN] && (cur_w[SIZE_W-1:0] != '0);
    hold     = prev_long && !desc_q[prev_idx][B_OWN];
    level_ok = fifo_pkt_ready || (fifo_bytes >= thr_b);
    go       = (st == S_IDLE) && eligible && !hold && level_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cur_idx   <= '0;
      tx_start  <= 1'b0;
      prev_long <= 1'b0;
      prev_idx  <= '0;
    end else begin
      tx_start <= go;
      if (go) st <= S_BUSY;
      if (st == S_BUSY && tx_done) begin
        st        <= S_IDLE;
        cur_idx   <= (cur_idx == LAST) ? '0 : cur_idx + 1'b1;
        prev_long <= (cur_w[SIZE_W-1:0] > SIZE_W'(LONG_LIMIT));
        prev_idx  <= cur_idx;
      end
    end
  end

  assign busy = (st == S_BUSY);

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  // R11
  ptr_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && tx_done) |=>
      (cur_idx == (($past(cur_idx) == LAST) ? '0 : $past(cur_idx) + 1'b1)));

  // R12
  long_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> !tx_start);
endmodule

// File: rtl/tx_desc_ctrl.sv
module tx_desc_ctrl
  import tx_desc_pkg::*;
#(
  parameter int NUM_DESC   = 4,
  parameter int CNT_W      = 12,
  parameter int SIZE_W     = 13,
  parameter int LONG_LIMIT = 1792,
  localparam int PW        = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_idx,
  input  logic [3:0]        wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [PW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  fifo_bytes,
  input  logic              fifo_pkt_ready,
  input  logic              dma_done,
  input  logic [PW-1:0]     dma_idx,
  input  logic              tx_done,
  input  logic              tx_ok,
  input  logic              tx_underrun,
  input  logic              tx_abort,
  input  logic              tx_carrier_lost,
  input  logic              tx_late_coll,
  input  logic              tx_hb_fail,
  input  logic [3:0]        tx_coll_cnt,
  input  logic              speed100,
  output logic              tx_start,
  output logic [PW-1:0]     cur_idx
);
  logic [WORD_W-1:0] desc_q [NUM_DESC];
  logic              busy;
  tx_stat_t          stat_in;

  always_comb begin
    stat_in.crs = tx_carrier_lost;
    stat_in.abt = tx_abort;
    stat_in.owc = tx_late_coll;
    stat_in.hb  = tx_hb_fail;
    stat_in.ncc = tx_coll_cnt;
    stat_in.tok = tx_ok;
    stat_in.tun = tx_underrun;
  end

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
    logic sel_w;
    assign sel_w = wr_en && (wr_idx == PW'(g));
    tx_desc_reg #(.SIZE_W(SIZE_W)) u_reg (
      .clk      (clk),
      .rst      (rst),
      .wr_full  (sel_w && (wr_be == 4'hF)),
      .wr_part  (sel_w && (wr_be != 4'hF)),
      .wr_data  (wr_data),
      .done_hit (tx_done && busy && (cur_idx == PW'(g))),
      .stat_in  (stat_in),
      .speed100 (speed100),
      .own_set  (dma_done && (dma_idx == PW'(g))),
      .q        (desc_q[g])
    );
  end

  tx_start_ctrl #(
    .NUM_DESC   (NUM_DESC),
    .CNT_W      (CNT_W),
    .SIZE_W     (SIZE_W),
    .LONG_LIMIT (LONG_LIMIT)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .desc_q         (desc_q),
    .fifo_bytes     (fifo_bytes),
    .fifo_pkt_ready (fifo_pkt_ready),
    .tx_done        (tx_done),
    .tx_start       (tx_start),
    .busy           (busy),
    .cur_idx        (cur_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= desc_q[rd_idx];
  end
endmodule

// File: tb/tx_desc_ctrl_tb_top.sv
module tx_desc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0;
  logic [1:0]  wr_idx = 0;
  logic [3:0]  wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [1:0]  rd_idx = 0;
  logic [31:0] rd_data;
  logic [11:0] fifo_bytes = 0;
  logic        fifo_pkt_ready = 0;
  logic        dma_done = 0;
  logic [1:0]  dma_idx = 0;
  logic        tx_done = 0, tx_ok = 0, tx_underrun = 0, tx_abort = 0;
  logic        tx_carrier_lost = 0, tx_late_coll = 0, tx_hb_fail = 0;
  logic [3:0]  tx_coll_cnt = 0;
  logic        speed100 = 0;
  logic        tx_start;
  logic [1:0]  cur_idx;

  int n_chk = 0, n_fail = 0, exp_cur = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  tx_desc_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .fifo_bytes(fifo_bytes), .fifo_pkt_ready(fifo_pkt_ready),
    .dma_done(dma_done), .dma_idx(dma_idx), .tx_done(tx_done), .tx_ok(tx_ok),
    .tx_underrun(tx_underrun), .tx_abort(tx_abort),
    .tx_carrier_lost(tx_carrier_lost), .tx_late_coll(tx_late_coll),
    .tx_hb_fail(tx_hb_fail), .tx_coll_cnt(tx_coll_cnt), .speed100(speed100),
    .tx_start(tx_start), .cur_idx(cur_idx)
  );

  // threshold code, fifo bytes, whole packet, start expected
  localparam int NV = 12;
  localparam int VEC [NV][4] = '{
    '{0, 7, 0, 0}, '{0, 8, 0, 1}, '{1, 31, 0, 0}, '{1, 32, 0, 1},
    '{2, 63, 0, 0}, '{5, 10, 1, 1}, '{63, 2015, 0, 0}, '{63, 2016, 0, 1},
    '{10, 319, 0, 0}, '{10, 320, 0, 1}, '{3, 96, 0, 1}, '{0, 0, 1, 1}
  };

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] idx, logic [3:0] be, logic [31:0] d);
    wr_en = 1; wr_idx = idx; wr_be = be; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] idx, output logic [31:0] v);
    rd_idx = idx;
    tick();
    v = rd_data;
  endtask

  task automatic finish_tx(string req);
    fifo_bytes = 0; fifo_pkt_ready = 0;
    tx_done = 1;
    tick();
    tx_done = 0; tx_ok = 0; tx_hb_fail = 0; tx_carrier_lost = 0; tx_coll_cnt = 0;
    exp_cur = (exp_cur + 1) % 4;
    chk(req, 32'(cur_idx), 32'(exp_cur));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    int c, n;
    tick(); tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 tx_start", 32'(tx_start), 0);
    chk("R1 cur_idx", 32'(cur_idx), 0);
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk("R1 desc", v, 32'h0000_2000);
    end
    // R3 partial write ignored
    wr(2'd1, 4'b0111, 32'h0005_0064);
    rd(2'd1, v);
    chk("R3 partial", v, 32'h0000_2000);
    // R2 full write readback
    wr(2'd1, 4'hF, 32'h0005_0064);
    rd(2'd1, v);
    chk("R2 full", v, 32'h0005_0064);

    // Table: R7 R8 R9 R11 R10
    for (int k = 0; k < NV; k++) begin
      wr(2'(exp_cur), 4'hF, (32'(VEC[k][0]) << 16) | 32'd100);
      fifo_bytes = 12'(VEC[k][1]);
      fifo_pkt_ready = VEC[k][2] != 0;
      tick();
      chk($sformatf("R7/R8/R9 vec%0d", k), 32'(tx_start), 32'(VEC[k][3]));
      if (VEC[k][3] != 0) begin
        fifo_bytes = 0; fifo_pkt_ready = 0;
        tick();
        chk("R10 no repeat", 32'(tx_start), 0);
        finish_tx("R11 advance");
      end else begin
        fifo_bytes = 0; fifo_pkt_ready = 0;
      end
    end

    // R6 status capture, 10 Mb/s
    c = exp_cur;
    wr(2'(c), 4'hF, 32'd100);
    fifo_bytes = 8;
    tick();
    chk("R6 start", 32'(tx_start), 1);
    tx_ok = 1; tx_coll_cnt = 5; tx_hb_fail = 1; tx_carrier_lost = 1;
    finish_tx("R11 advance");
    rd(2'(c), v);
    chk("R6 status", v, 32'h9500_8064);
    // R6 heartbeat forced at 100 Mb/s
    c = exp_cur;
    speed100 = 1;
    wr(2'(c), 4'hF, 32'd100);
    fifo_bytes = 8;
    tick();
    tx_ok = 1; tx_coll_cnt = 5; tx_hb_fail = 1; tx_carrier_lost = 1;
    finish_tx("R11 advance");
    speed100 = 0;
    rd(2'(c), v);
    chk("R6 hb 100M", v, 32'h8500_8064);
    // R4 size write clears status, ones ignored
    wr(2'(c), 4'hF, 32'hF0FF_C032);
    rd(2'(c), v);
    chk("R4 clear", v, 32'h003F_0032);

    // R10 zero size and hardware-owned not eligible
    c = exp_cur;
    wr(2'(c), 4'hF, 32'd0);
    fifo_pkt_ready = 1;
    tick(); tick();
    chk("R10 size0", 32'(tx_start), 0);
    wr(2'(c), 4'hF, 32'h0000_2064);
    tick();
    chk("R10 own1", 32'(tx_start), 0);
    fifo_pkt_ready = 0;

    // R12 long descriptor holds the next one until OWN, R5 dma sets OWN
    c = exp_cur;
    wr(2'(c), 4'hF, 32'd1793);
    fifo_pkt_ready = 1;
    tick();
    chk("R12 long start", 32'(tx_start), 1);
    finish_tx("R11 advance");
    n = exp_cur;
    wr(2'(n), 4'hF, 32'd100);
    fifo_pkt_ready = 1;
    tick();
    chk("R12 held", 32'(tx_start), 0);
    tick();
    chk("R12 held", 32'(tx_start), 0);
    dma_done = 1; dma_idx = 2'(c);
    tick();
    dma_done = 0;
    chk("R12 held at dma", 32'(tx_start), 0);
    tick();
    chk("R12 released", 32'(tx_start), 1);
    finish_tx("R11 advance");
    rd(2'(c), v);
    chk("R5 own set", v, 32'h0000_2701);
    // R12 exactly 1792 causes no hold
    c = exp_cur;
    wr(2'(c), 4'hF, 32'd1792);
    fifo_pkt_ready = 1;
    tick();
    chk("R12 1792 start", 32'(tx_start), 1);
    finish_tx("R11 advance");
    n = exp_cur;
    wr(2'(n), 4'hF, 32'd100);
    fifo_pkt_ready = 1;
    tick();
    chk("R12 no hold", 32'(tx_start), 1);
    finish_tx("R11 advance");

    done_flag = 1;
    summary();
  end
endmodule